// File: doc/BRIEF.md
# Tag Store with Shared Round-Robin Victim Counter

This block is the tag and valid-bit store of a 4-way set-associative cache. Each lookup carries a set index and a tag. The block compares the tag with the four ways of the indexed set. One clock later it reports a hit or a miss and a way number. On a miss it fills the tag into a victim way, and it reports which tag was pushed out and whether that tag was valid. Data storage, write policies and the memory side stay outside; the block only keeps tags and valid bits and decides which way to replace.

There is one 2-bit victim counter, and every set shares it. It does not belong to any one set. It moves forward only when a fill happens. A miss in one set therefore changes which way the next miss in any other set will replace. The victim is always the way the counter names, even when another way in the same set is still empty. This makes hit/miss behaviour hard to predict statically. The hardware, however, stays a single tiny counter. The caller splits an address into the set index (the bits above the word offset) and the tag (the bits above the index).

Top module: `rrts_tag_store`

## Requirements
- R1: After reset every way of every set is invalid and the victim counter is 0. The first miss after reset therefore fills way 0 and reports no valid evicted tag.
- R2: A lookup is taken on a rising edge where `lkp_vld_i` is high. Its result appears one cycle later with `rsp_vld_o` high for exactly that one cycle.
- R3: A lookup hits when a valid way of the indexed set holds an equal tag. `rsp_way_o` then gives that way as 0 to 3. No set ever holds the same valid tag in two ways.
- R4: A hit changes neither the victim counter nor any stored tag or valid bit.
- R5: On a miss the tag is written into the way named by the victim counter, even if another way of that set is invalid. `rsp_way_o` reports that way. In the same cycle the counter advances by one, modulo 4.
- R6: On a miss `rsp_evict_vld_o` and `rsp_evict_tag_o` give the valid bit and tag that the victim way held before the fill. On a hit `rsp_evict_vld_o` is 0.
- R7: The victim counter is shared by all sets, so a fill in one set changes the victim way of the next miss in every other set.
- R8: Lookups may come on consecutive cycles. Each lookup sees the fill made by the lookup in the cycle before it.
- R9: A cycle with `lkp_vld_i` low produces no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_vld_i | input | 1 | Lookup request strobe |
| lkp_set_i | input | SET_W | Set index of the lookup |
| lkp_tag_i | input | TAG_W | Tag of the lookup |
| rsp_vld_o | output | 1 | Response strobe, one cycle after the request |
| rsp_hit_o | output | 1 | 1 = hit, 0 = miss |
| rsp_way_o | output | 2 | Way that hit, or way filled on a miss |
| rsp_evict_vld_o | output | 1 | Evicted way held a valid tag (miss only) |
| rsp_evict_tag_o | output | TAG_W | Tag held by the filled way before the fill |

## Verification
The assertions check the following on every cycle:
- The counter holds on non-fill cycles and steps by one on fills.
- A response strobe follows each request and only a request.
- At most one way matches.
- A miss reports the counter's prior value as its way.
- A hit never reports an eviction.

The bench scenarios are needed to show the cross-set effects of the shared counter. They also show that a fill skips an empty way, that the reported evicted tag is right, that back-to-back lookups see each other's fills, and that reset clears the contents. A reference model of the tags and the counter in the bench predicts each response.

// File: rtl/rrts_pkg.sv
package rrts_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  typedef logic [WAY_W-1:0] way_t;
endpackage

// File: rtl/rrts_victim_ctr.sv
module rrts_victim_ctr
  import rrts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output way_t ptr_o
);
  way_t ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) ptr_d = ptr_q + way_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R4 / R9: no fill, no movement
  p_ctr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> ptr_o == $past(ptr_o));
  // R5: each fill steps the pointer by one, wrapping at 4
  p_ctr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> ptr_o == way_t'($past(ptr_o) + way_t'(1)));
endmodule

// File: rtl/rrts_tag_ram.sv
module rrts_tag_ram
  import rrts_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      rd_set_i,
  output logic [WAYS*TAG_W-1:0] rd_tags_o,
  output logic [WAYS-1:0]       rd_vld_o,
  input  logic                  wr_en_i,
  input  logic [SET_W-1:0]      wr_set_i,
  input  way_t                  wr_way_i,
  input  logic [TAG_W-1:0]      wr_tag_i
);
  logic [WAYS-1:0] vld_q [SETS];
  logic [WAYS-1:0] vld_d [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = vld_q[s];
    end
    if (wr_en_i) vld_d[wr_set_i][wr_way_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= vld_d[s];
    end
  end

  // tag payload carries no reset; it is qualified by the valid bits
  always_ff @(posedge clk) begin
    if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tags_o[w*TAG_W +: TAG_W] = tag_q[rd_set_i][w];
    assign rd_vld_o[w]                 = vld_q[rd_set_i][w];
  end

  // R5: the filled entry reads back valid on the next cycle
  p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> vld_q[$past(wr_set_i)][$past(wr_way_i)]);
endmodule

// File: rtl/rrts_match.sv
module rrts_match
  import rrts_pkg::*;
#(
  parameter int TAG_W = 8
)(
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]       vld_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [WAYS-1:0]       match_o,
  output logic                  hit_o,
  output way_t                  way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) way_o = way_t'(w);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/rrts_tag_store.sv
module rrts_tag_store
  import rrts_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_vld_i,
  input  logic [SET_W-1:0] lkp_set_i,
  input  logic [TAG_W-1:0] lkp_tag_i,
  output logic             rsp_vld_o,
  output logic             rsp_hit_o,
  output logic [1:0]       rsp_way_o,
  output logic             rsp_evict_vld_o,
  output logic [TAG_W-1:0] rsp_evict_tag_o
);
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS-1:0]       set_vld;
  logic [WAYS-1:0]       match_vec;
  logic                  hit;
  way_t                  hit_way;
  way_t                  victim;
  logic                  fill;

  rrts_tag_ram #(.SETS(SETS), .TAG_W(TAG_W)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set_i (lkp_set_i),
    .rd_tags_o(set_tags),
    .rd_vld_o (set_vld),
    .wr_en_i  (fill),
    .wr_set_i (lkp_set_i),
    .wr_way_i (victim),
    .wr_tag_i (lkp_tag_i)
  );

  rrts_match #(.TAG_W(TAG_W)) u_match (
    .tags_i (set_tags),
    .vld_i  (set_vld),
    .tag_i  (lkp_tag_i),
    .match_o(match_vec),
    .hit_o  (hit),
    .way_o  (hit_way)
  );

  rrts_victim_ctr u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv_i(fill),
    .ptr_o(victim)
  );

  assign fill = lkp_vld_i && !hit;

  logic             vld_q, vld_d;
  logic             hit_q, hit_d;
  way_t             way_q, way_d;
  logic             ev_vld_q, ev_vld_d;
  logic [TAG_W-1:0] ev_tag_q, ev_tag_d;

  always_comb begin
    vld_d    = lkp_vld_i;
    hit_d    = hit_q;
    way_d    = way_q;
    ev_vld_d = ev_vld_q;
    ev_tag_d = ev_tag_q;
    if (lkp_vld_i) begin
      hit_d    = hit;
      way_d    = hit ? hit_way : victim;
      ev_vld_d = !hit && set_vld[victim];
      ev_tag_d = set_tags[victim*TAG_W +: TAG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      hit_q    <= 1'b0;
      way_q    <= '0;
      ev_vld_q <= 1'b0;
      ev_tag_q <= '0;
    end else begin
      vld_q    <= vld_d;
      hit_q    <= hit_d;
      way_q    <= way_d;
      ev_vld_q <= ev_vld_d;
      ev_tag_q <= ev_tag_d;
    end
  end

  assign rsp_vld_o       = vld_q;
  assign rsp_hit_o       = hit_q;
  assign rsp_way_o       = way_q;
  assign rsp_evict_vld_o = ev_vld_q;
  assign rsp_evict_tag_o = ev_tag_q;

  // R2: one response per request, one cycle later
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_vld_i |=> rsp_vld_o);
  // R9: idle cycles give no response
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_vld_i |=> !rsp_vld_o);
  // R3: never two ways with the same valid tag in a set
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_vld_i |-> $onehot0(match_vec));
  // R6: a hit reports no eviction
  p_hit_no_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o && rsp_hit_o |-> !rsp_evict_vld_o);
  // R5: a miss reports the counter value that was current at the lookup
  p_miss_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (rsp_way_o == $past(victim)) && !rsp_hit_o);
endmodule

// File: tb/sim_rrts_tag_store.sv
`timescale 1ns/1ps
module sim_rrts_tag_store;
  localparam int SETS  = 16;
  localparam int TAG_W = 8;
  localparam int SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lkp_vld_i;
  logic [SET_W-1:0] lkp_set_i;
  logic [TAG_W-1:0] lkp_tag_i;
  logic             rsp_vld_o, rsp_hit_o, rsp_evict_vld_o;
  logic [1:0]       rsp_way_o;
  logic [TAG_W-1:0] rsp_evict_tag_o;

  always #2.5 clk = ~clk;

  rrts_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lkp_vld_i(lkp_vld_i), .lkp_set_i(lkp_set_i),
    .lkp_tag_i(lkp_tag_i), .rsp_vld_o(rsp_vld_o), .rsp_hit_o(rsp_hit_o),
    .rsp_way_o(rsp_way_o), .rsp_evict_vld_o(rsp_evict_vld_o),
    .rsp_evict_tag_o(rsp_evict_tag_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model
  logic [TAG_W-1:0] m_tag [SETS][4];
  bit               m_vld [SETS][4];
  int               m_ctr;

  // expected response of the lookup in flight
  bit               e_hit, e_ev;
  int               e_way;
  logic [TAG_W-1:0] e_tag;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    m_ctr = 0;
  endtask

  task automatic model_access(input int s, input logic [TAG_W-1:0] t);
    e_hit = 0; e_way = 0; e_ev = 0; e_tag = '0;
    for (int w = 0; w < 4; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin e_hit = 1; e_way = w; end
    if (!e_hit) begin
      e_way = m_ctr;
      e_ev  = m_vld[s][m_ctr];
      e_tag = m_tag[s][m_ctr];
      m_tag[s][m_ctr] = t;
      m_vld[s][m_ctr] = 1;
      m_ctr = (m_ctr + 1) % 4;
    end
  endtask

  task automatic check_rsp(input string rq);
    chk(rq, "rsp_vld", int'(rsp_vld_o), 1);
    chk(rq, "hit", int'(rsp_hit_o), int'(e_hit));
    chk(rq, "way", int'(rsp_way_o), e_way);
    chk(rq, "evict_vld", int'(rsp_evict_vld_o), int'(e_ev));
    if (e_ev) chk(rq, "evict_tag", int'(rsp_evict_tag_o), int'(e_tag));
  endtask

  // drive on a falling edge, check on the next falling edge
  task automatic lookup(input int s, input logic [TAG_W-1:0] t, input string rq);
    @(negedge clk);
    lkp_vld_i = 1'b1; lkp_set_i = SET_W'(s); lkp_tag_i = t;
    model_access(s, t);
    @(negedge clk);
    lkp_vld_i = 1'b0;
    check_rsp(rq);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; lkp_vld_i = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: reset state and first miss
  task automatic t_reset();
    apply_reset();
    @(negedge clk);
    chk("R1", "rsp_vld after reset", int'(rsp_vld_o), 0);
    lookup(3, 8'h11, "R1");
    chk("R1", "first fill way", int'(rsp_way_o), 0);
  endtask

  // R3, R4, R9: fill a set, hit in it, idle, then miss
  task automatic t_fill_hit();
    apply_reset();
    lookup(0, 8'hA0, "R5");
    lookup(0, 8'hA1, "R5");
    lookup(0, 8'hA2, "R5");
    lookup(0, 8'hA3, "R5");
    chk("R5", "fourth fill way", int'(rsp_way_o), 3);
    lookup(0, 8'hA1, "R3");
    chk("R3", "hit way", int'(rsp_way_o), 1);
    lookup(0, 8'hA3, "R4");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "no response when idle", int'(rsp_vld_o), 0);
    end
    lookup(0, 8'hB0, "R6");
    chk("R4", "victim after hits", int'(rsp_way_o), 0);
    chk("R6", "evicted tag", int'(rsp_evict_tag_o), 8'hA0);
    lookup(0, 8'hA1, "R6");
    chk("R6", "hit keeps evict_vld low", int'(rsp_evict_vld_o), 0);
  endtask

  // R5, R7: shared counter skips empty ways and crosses sets
  task automatic t_shared();
    apply_reset();
    lookup(1, 8'h21, "R7");
    lookup(2, 8'h31, "R7");
    lookup(5, 8'h51, "R5");
    chk("R5", "empty set filled at counter way", int'(rsp_way_o), 2);
    chk("R5", "no valid eviction", int'(rsp_evict_vld_o), 0);
    lookup(1, 8'h22, "R7");
    chk("R7", "way chosen by other sets' fills", int'(rsp_way_o), 3);
    lookup(1, 8'h23, "R7");
    chk("R7", "wrap evicts way 0", int'(rsp_way_o), 0);
    chk("R7", "evicted valid", int'(rsp_evict_vld_o), 1);
    chk("R7", "evicted tag", int'(rsp_evict_tag_o), 8'h21);
    lookup(2, 8'h31, "R3");
  endtask

  // R8: back-to-back lookups
  task automatic t_b2b();
    apply_reset();
    @(negedge clk);
    lkp_vld_i = 1'b1; lkp_set_i = 4'd7; lkp_tag_i = 8'h77;
    model_access(7, 8'h77);
    @(negedge clk);
    check_rsp("R8");
    lkp_set_i = 4'd7; lkp_tag_i = 8'h77;
    model_access(7, 8'h77);
    @(negedge clk);
    check_rsp("R8");
    lkp_set_i = 4'd7; lkp_tag_i = 8'h78;
    model_access(7, 8'h78);
    @(negedge clk);
    lkp_vld_i = 1'b0;
    check_rsp("R8");
    chk("R8", "second miss way", int'(rsp_way_o), 1);
    @(negedge clk);
    chk("R2", "single response strobe", int'(rsp_vld_o), 0);
  endtask

  // R1: reset in mid-run clears contents and counter
  task automatic t_midreset();
    lookup(9, 8'h99, "R1");
    lookup(9, 8'h99, "R1");
    chk("R1", "hit before reset", int'(rsp_hit_o), 1);
    apply_reset();
    lookup(9, 8'h99, "R1");
    chk("R1", "miss after reset", int'(rsp_hit_o), 0);
    chk("R1", "counter cleared", int'(rsp_way_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; lkp_vld_i = 1'b0; lkp_set_i = '0; lkp_tag_i = '0;
    model_reset();
    t_reset();
    t_fill_hit();
    t_shared();
    t_b2b();
    t_midreset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule